// File: doc/BRIEF.md
# Register-Transfer Microoperation Datapath

This block holds a small file of general registers (four 8-bit words by default) that run on a free-running clock. A register changes only when its load control is high; otherwise a feedback multiplexer returns its own value, so the clock is never gated. Each cycle a 4-bit opcode selects one whole-word microoperation: a transfer, arithmetic, bitwise logic or a zero-fill shift. The operands come from any two registers, and the result goes to any destination register.

Two control variables, K1 and K2, drive a dedicated transfer into R0 that runs alongside the opcode. K1 also enables an add/subtract of R2 into R1, and a mode bit picks between the sum and the two's-complement difference. A carry flag keeps the carry-out of the last arithmetic operation. A shift-out flag keeps the bit that the last shift pushed out of the word. All updates take effect at the next rising clock edge.

Top module: `rt_datapath`

## Requirements
- R1: A synchronous active-high reset clears every register, the carry flag and the shift-out flag to zero at the next rising edge.
- R2: Opcode 0 (no-op) and the unused codes 13, 14 and 15, with K1 = K2 = 0, leave every register and both flags unchanged.
- R3: Opcode 1 copies register `src_a` into register `dst`. Any register may be the source or the destination.
- R4: The arithmetic opcodes write `dst` and record the carry-out of the (W+1)-bit sum in the carry flag: 2 = A+B, 4 = ~A+1, 5 = B+~A+1, 6 = A+1, and 7 = A plus all-ones (decrement). Here A is `src_a` and B is `src_b`.
- R5: The logic opcodes act on whole words: 3 = ~A, 8 = A|B, 9 = A&B, 10 = A^B. For A = 0xAA and B = 0xF0 they give 0x55, 0xFA, 0xA0 and 0x5A.
- R6: Opcode 11 shifts A left and opcode 12 shifts A right, each with zero fill. The bit shifted out is stored in the shift-out flag, and every other opcode leaves that flag unchanged. For A = 0xC9 the results are 0x92 and 0x64, and in both cases the flag becomes 1.
- R7: When K1 = 1, R1 becomes R1+R2 if `x_sub` = 0 and R1+~R2+1 if `x_sub` = 1, and the carry flag takes that sum's carry-out. When K1 = 0, this path leaves R1 alone.
- R8: K1 = 1 loads R0 from the old R1, whatever K2 is. K1 = 0 with K2 = 1 loads R0 from R2. With K1 = K2 = 0 this path leaves R0 alone.
- R9: In the same cycle, the K1/K2 transfer overrides an opcode result aimed at R0, and the K1 add/subtract overrides an opcode result aimed at R1. An opcode result aimed at any other register is written in parallel. An arithmetic opcode still records its carry unless K1 = 1, in which case the K1 carry wins.
- R10: Register Ri appears on `regs_o[8*i+7:8*i]`, and all outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| uop | input | 4 | Microoperation opcode |
| dst | input | 2 | Destination register index |
| src_a | input | 2 | First operand register index |
| src_b | input | 2 | Second operand register index |
| k1 | input | 1 | Control variable: R0 from R1, enable R1 add/subtract |
| k2 | input | 1 | Control variable: R0 from R2 when K1 is low |
| x_sub | input | 1 | Mode bit for the K1 path: 0 add, 1 subtract |
| regs_o | output | 32 | All register contents, R0 in the low byte |
| carry_o | output | 1 | Carry flag |
| shout_o | output | 1 | Shift-out flag |

## Verification
Every result of this block, whether a register write, the carry or the shift-out bit, is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and at that moment pushes the complete expected state (all registers plus both flags) into a queue. A monitor pops one entry 1 ns after the following rising edge and compares it against the outputs. Because the bench has no data input, it builds operand values such as 0xAA, 0xF0 and 0xC9 by clearing a register with XOR and then applying shift and increment steps. Each of those steps is checked as well.

// File: rtl/rtm_pkg.sv
`timescale 1ns/1ps
package rtm_pkg;
    localparam int unsigned UOP_W = 4;

    typedef enum logic [UOP_W-1:0] {
        UOP_NOP  = 4'd0,
        UOP_MOV  = 4'd1,
        UOP_ADD  = 4'd2,
        UOP_CPL  = 4'd3,
        UOP_NEG  = 4'd4,
        UOP_RSUB = 4'd5,
        UOP_INC  = 4'd6,
        UOP_DEC  = 4'd7,
        UOP_OR   = 4'd8,
        UOP_AND  = 4'd9,
        UOP_XOR  = 4'd10,
        UOP_SHL  = 4'd11,
        UOP_SHR  = 4'd12
    } uop_e;
endpackage

// File: rtl/rtm_regcell.sv
`timescale 1ns/1ps
module rtm_regcell #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // feedback multiplexer: hold on ld = 0, take d on ld = 1
    always_comb nxt = ld ? d : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/rtm_addsub.sv
`timescale 1ns/1ps
module rtm_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
        res  = sum[W-1:0];
        cout = sum[W];
    end
endmodule

// File: rtl/rtm_uop_unit.sv
`timescale 1ns/1ps
module rtm_uop_unit
    import rtm_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [UOP_W-1:0] op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     res,
    output logic             wr,
    output logic             arith,
    output logic             cout,
    output logic             shift,
    output logic             shift_bit
);
    localparam logic [W:0] ONE  = {{W{1'b0}}, 1'b1};
    localparam logic [W:0] ONES = {1'b0, {W{1'b1}}};

    logic [W:0] sum;

    always_comb begin
        sum       = '0;
        res       = '0;
        wr        = 1'b1;
        arith     = 1'b0;
        shift     = 1'b0;
        shift_bit = 1'b0;
        unique case (op)
            UOP_MOV:  res = a;
            UOP_CPL:  res = ~a;
            UOP_OR:   res = a | b;
            UOP_AND:  res = a & b;
            UOP_XOR:  res = a ^ b;
            UOP_ADD:  begin sum = {1'b0, a} + {1'b0, b};        arith = 1'b1; end
            UOP_NEG:  begin sum = {1'b0, ~a} + ONE;             arith = 1'b1; end
            UOP_RSUB: begin sum = {1'b0, b} + {1'b0, ~a} + ONE; arith = 1'b1; end
            UOP_INC:  begin sum = {1'b0, a} + ONE;              arith = 1'b1; end
            UOP_DEC:  begin sum = {1'b0, a} + ONES;             arith = 1'b1; end
            UOP_SHL:  begin res = {a[W-2:0], 1'b0}; shift = 1'b1; shift_bit = a[W-1]; end
            UOP_SHR:  begin res = {1'b0, a[W-1:1]}; shift = 1'b1; shift_bit = a[0];   end
            default:  wr = 1'b0;
        endcase
        if (arith) res = sum[W-1:0];
        cout = sum[W];
    end
endmodule

// File: rtl/rt_datapath.sv
`timescale 1ns/1ps
module rt_datapath
    import rtm_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [UOP_W-1:0]        uop,
    input  logic [$clog2(NREG)-1:0] dst,
    input  logic [$clog2(NREG)-1:0] src_a,
    input  logic [$clog2(NREG)-1:0] src_b,
    input  logic                    k1,
    input  logic                    k2,
    input  logic                    x_sub,
    output logic [NREG*W-1:0]       regs_o,
    output logic                    carry_o,
    output logic                    shout_o
);
    localparam int unsigned SW = $clog2(NREG);

    logic [W-1:0] rq [NREG];
    logic [W-1:0] u_res, as_res;
    logic         u_wr, u_arith, u_cout, u_shift, u_sbit, as_cout;
    logic         carry_q, shout_q;

    rtm_uop_unit #(.W(W)) u_uop (
        .op(uop), .a(rq[src_a]), .b(rq[src_b]),
        .res(u_res), .wr(u_wr), .arith(u_arith), .cout(u_cout),
        .shift(u_shift), .shift_bit(u_sbit)
    );

    rtm_addsub #(.W(W)) u_addsub (
        .a(rq[1]), .b(rq[2]), .sub(x_sub), .res(as_res), .cout(as_cout)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic         ld;
        logic [W-1:0] d;
        logic         op_hit;

        assign op_hit = u_wr && (dst == SW'(g));

        if (g == 0) begin : g_r0
            // K1 beats K2, and both beat the opcode
            always_comb begin
                if (k1)          begin ld = 1'b1; d = rq[1]; end
                else if (k2)     begin ld = 1'b1; d = rq[2]; end
                else             begin ld = op_hit; d = u_res; end
            end
        end else if (g == 1) begin : g_r1
            always_comb begin
                if (k1)          begin ld = 1'b1; d = as_res; end
                else             begin ld = op_hit; d = u_res; end
            end
        end else begin : g_rn
            always_comb begin
                ld = op_hit;
                d  = u_res;
            end
        end

        rtm_regcell #(.W(W)) u_cell (
            .clk(clk), .rst(rst), .ld(ld), .d(d), .q(rq[g])
        );

        assign regs_o[g*W +: W] = rq[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            shout_q <= 1'b0;
        end else begin
            if (k1)           carry_q <= as_cout;
            else if (u_arith) carry_q <= u_cout;
            if (u_shift)      shout_q <= u_sbit;
        end
    end

    assign carry_o = carry_q;
    assign shout_o = shout_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0) && !carry_o && !shout_o);

    // R2
    unused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uop >= 4'd13 && !k1 && !k2) |=> $stable(regs_o) && $stable(carry_o) && $stable(shout_o));

    // R6
    shout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uop != UOP_SHL && uop != UOP_SHR) |=> $stable(shout_o));

    // R7
    k1_add_chk: assert property (@(posedge clk) disable iff (rst)
        (k1 && !x_sub) |=> regs_o[2*W-1:W] == W'($past(regs_o[2*W-1:W]) + $past(regs_o[3*W-1:2*W])));

    // R8
    k1_to_r0_chk: assert property (@(posedge clk) disable iff (rst)
        k1 |=> regs_o[W-1:0] == $past(regs_o[2*W-1:W]));

    // R8
    k2_to_r0_chk: assert property (@(posedge clk) disable iff (rst)
        (!k1 && k2) |=> regs_o[W-1:0] == $past(regs_o[3*W-1:2*W]));
endmodule

// File: tb/rt_datapath_tb.sv
`timescale 1ns/1ps
module rt_datapath_tb;
    localparam int W = 8;
    localparam int N = 4;

    localparam logic [3:0] OP_NOP = 4'd0, OP_MOV = 4'd1, OP_ADD = 4'd2, OP_CPL = 4'd3,
                           OP_NEG = 4'd4, OP_RSUB = 4'd5, OP_INC = 4'd6, OP_DEC = 4'd7,
                           OP_OR = 4'd8, OP_AND = 4'd9, OP_XOR = 4'd10, OP_SHL = 4'd11,
                           OP_SHR = 4'd12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic [3:0] uop = '0;
    logic [1:0] dst = '0, sa = '0, sb = '0;
    logic       k1 = 1'b0, k2 = 1'b0, xs = 1'b0;
    logic [N*W-1:0] regs;
    logic           carry, shout;

    rt_datapath #(.W(W), .NREG(N)) u_dut (
        .clk(clk), .rst(rst), .uop(uop), .dst(dst), .src_a(sa), .src_b(sb),
        .k1(k1), .k2(k2), .x_sub(xs), .regs_o(regs), .carry_o(carry), .shout_o(shout)
    );

    logic [W-1:0] m [N];
    logic         mc = 1'b0, ms = 1'b0;
    logic [N*W+1:0] q_exp [$];
    string          q_tag [$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic step(input logic r, input logic [3:0] op, input logic [1:0] d,
                        input logic [1:0] a_i, input logic [1:0] b_i,
                        input logic c1, input logic c2, input logic cx, input string tag);
        logic [W-1:0] n [N];
        logic [W-1:0] a, b, res;
        logic [W:0]   s;
        logic         nc, ns, wr, ar;
        @(negedge clk);
        rst = r; uop = op; dst = d; sa = a_i; sb = b_i; k1 = c1; k2 = c2; xs = cx;
        n = m; nc = mc; ns = ms;
        a = m[a_i]; b = m[b_i];
        s = '0; res = '0; wr = 1'b1; ar = 1'b0;
        case (op)
            OP_MOV:  res = a;
            OP_CPL:  res = ~a;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_ADD:  begin s = {1'b0, a} + {1'b0, b};          ar = 1'b1; end
            OP_NEG:  begin s = {1'b0, ~a} + 9'd1;              ar = 1'b1; end
            OP_RSUB: begin s = {1'b0, b} + {1'b0, ~a} + 9'd1;  ar = 1'b1; end
            OP_INC:  begin s = {1'b0, a} + 9'd1;               ar = 1'b1; end
            OP_DEC:  begin s = {1'b0, a} + 9'h0FF;             ar = 1'b1; end
            OP_SHL:  begin res = {a[6:0], 1'b0}; ns = a[7]; end
            OP_SHR:  begin res = {1'b0, a[7:1]}; ns = a[0]; end
            default: wr = 1'b0;
        endcase
        if (ar) begin res = s[7:0]; nc = s[8]; end
        if (wr && !(d == 2'd0 && (c1 || c2)) && !(d == 2'd1 && c1)) n[d] = res;
        if (c1) begin
            n[0] = m[1];
            s = {1'b0, m[1]} + {1'b0, cx ? ~m[2] : m[2]} + {8'd0, cx};
            n[1] = s[7:0];
            nc = s[8];
        end else if (c2) begin
            n[0] = m[2];
        end
        if (r) begin
            for (int i = 0; i < N; i++) n[i] = '0;
            nc = 1'b0; ns = 1'b0;
        end
        m = n; mc = nc; ms = ns;
        q_exp.push_back({ms, mc, m[3], m[2], m[1], m[0]});
        q_tag.push_back(tag);
    endtask

    task automatic op_step(input logic [3:0] op, input logic [1:0] d, input logic [1:0] a,
                           input logic [1:0] b, input string tag);
        step(1'b0, op, d, a, b, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic load_const(input logic [1:0] d, input logic [7:0] v);
        op_step(OP_XOR, d, d, d, "R5");
        for (int i = 7; i >= 0; i--) begin
            op_step(OP_SHL, d, d, d, "R6");
            if (v[i]) op_step(OP_INC, d, d, d, "R4");
        end
    endtask

    // monitor: compare one edge after each stimulus
    initial begin
        logic [N*W+1:0] e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if ({shout, carry, regs} !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, {shout, carry, regs}, e);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m[i] = '0;
        // R1 reset state
        step(1'b1, OP_NOP, 0, 0, 0, 0, 0, 0, "R1");
        step(1'b1, OP_NOP, 0, 0, 0, 0, 0, 0, "R1");
        // operands
        load_const(2'd1, 8'hAA);
        load_const(2'd2, 8'hF0);
        // R5 logic
        op_step(OP_OR,  2'd0, 2'd1, 2'd2, "R5");
        op_step(OP_AND, 2'd3, 2'd1, 2'd2, "R5");
        op_step(OP_XOR, 2'd0, 2'd1, 2'd2, "R5");
        op_step(OP_CPL, 2'd3, 2'd1, 2'd2, "R5");
        // R3 transfers
        op_step(OP_MOV, 2'd3, 2'd1, 2'd0, "R3");
        op_step(OP_MOV, 2'd0, 2'd2, 2'd0, "R3");
        op_step(OP_MOV, 2'd2, 2'd2, 2'd0, "R3");
        // R2 no-op and unused codes
        op_step(OP_NOP, 2'd0, 2'd1, 2'd2, "R2");
        op_step(4'd13,  2'd0, 2'd1, 2'd2, "R2");
        op_step(4'd14,  2'd3, 2'd1, 2'd2, "R2");
        op_step(4'd15,  2'd1, 2'd1, 2'd2, "R2");
        // R6 shifts
        load_const(2'd3, 8'hC9);
        op_step(OP_SHL, 2'd0, 2'd3, 2'd0, "R6");
        op_step(OP_SHR, 2'd0, 2'd3, 2'd0, "R6");
        op_step(OP_SHR, 2'd0, 2'd0, 2'd0, "R6");
        op_step(OP_OR,  2'd0, 2'd3, 2'd1, "R6");
        // R4 arithmetic and carry
        op_step(OP_ADD,  2'd0, 2'd1, 2'd2, "R4");
        op_step(OP_NEG,  2'd3, 2'd2, 2'd0, "R4");
        op_step(OP_RSUB, 2'd0, 2'd1, 2'd2, "R4");
        op_step(OP_RSUB, 2'd0, 2'd2, 2'd1, "R4");
        op_step(OP_XOR,  2'd3, 2'd3, 2'd3, "R4");
        op_step(OP_NEG,  2'd0, 2'd3, 2'd0, "R4");
        op_step(OP_DEC,  2'd3, 2'd3, 2'd0, "R4");
        op_step(OP_INC,  2'd0, 2'd3, 2'd0, "R4");
        op_step(OP_DEC,  2'd3, 2'd3, 2'd0, "R4");
        op_step(OP_MOV,  2'd3, 2'd3, 2'd0, "R4");
        // R7 / R8 control variables
        step(1'b0, OP_NOP, 0, 0, 0, 1, 0, 0, "R7");
        step(1'b0, OP_NOP, 0, 0, 0, 1, 0, 1, "R7");
        step(1'b0, OP_NOP, 0, 0, 0, 1, 1, 1, "R8");
        step(1'b0, OP_NOP, 0, 0, 0, 0, 1, 0, "R8");
        step(1'b0, OP_NOP, 0, 0, 0, 0, 0, 1, "R8");
        // R9 conflicts
        step(1'b0, OP_MOV, 2'd0, 2'd3, 0, 0, 1, 0, "R9");
        step(1'b0, OP_INC, 2'd3, 2'd3, 0, 0, 1, 0, "R9");
        step(1'b0, OP_CPL, 2'd1, 2'd3, 0, 1, 0, 0, "R9");
        step(1'b0, OP_INC, 2'd2, 2'd3, 0, 1, 0, 1, "R9");
        step(1'b0, OP_ADD, 2'd0, 2'd3, 2'd3, 0, 1, 0, "R9");
        // R10 lane positions after distinct loads, then R1 reset again
        load_const(2'd0, 8'h11);
        load_const(2'd3, 8'h83);
        op_step(OP_MOV, 2'd1, 2'd0, 2'd0, "R10");
        step(1'b1, OP_ADD, 2'd2, 2'd1, 2'd2, 1, 1, 0, "R1");
        step(1'b0, OP_NOP, 0, 0, 0, 0, 0, 0, "R2");
        @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule